// File: doc/BRIEF.md
# SDRAM Command Timing Guard with Refresh Scheduler

This block sits in front of a single-data-rate SDRAM, between whatever produces memory commands and the pins that carry them. A command arrives with a bank number on a valid/ready handshake. The block lowers `req_ready` until every timing rule that governs that command has been met. These rules cover the bank being addressed, the other banks, and the whole device after a refresh or a mode-register load. The command moves on the edge where `req_valid` and `req_ready` are both high, and `issue` marks that edge. Each timing limit is given in nanoseconds and is turned into a clock count at elaboration. The count is the limit divided by the clock period (`CLK_PS`, in picoseconds), with any fraction rounded up.

The handshake rules for back-pressure are as follows. `req_ready` depends only on `req_cmd`, `req_bank` and internal state, and never on `req_valid`. A source therefore may present a command and wait. It may also change or withdraw a command that has not been accepted, because nothing is held inside the block. No command is queued. The source decides the order, and the block only delays each command.

A separate interval timer runs from reset and produces the refresh cadence. The default interval is 7812 ns, which is 64 ms spread over 8192 refreshes, rounded down so refreshes are never late. Each elapsed interval adds one owed refresh, up to `PEND_MAX`. `refresh_due` stays high while at least one refresh is owed, so a source that holds a row open for a long time can pay the debt later.

Top module: `sdram_timing_guard`

## Requirements
- R1: A read or write, with or without auto precharge, to a bank is accepted no sooner than RCD cycles after that bank's activate; a bank whose RCD has already expired is not held by an activate to another bank.
- R2: A single-bank precharge waits RAS cycles after that bank's activate; a precharge-all waits until every bank has met its own precharge limit.
- R3: An activate to a bank waits both RC cycles after that bank's previous activate and RP cycles after its precharge.
- R4: Any two activates are at least RRD cycles apart, whatever banks they address.
- R5: A precharge after a plain write waits until BURST_LEN-1+WRC cycles after the write, where WRC is 1 when the clock period is at least the write-recovery time and 2 otherwise (and not before RAS has expired).
- R6: After a write with auto precharge, the same bank's next activate waits max(BURST_LEN-1+WRC, remaining RAS) + RP cycles, and also RC from its activate.
- R7: After a read with auto precharge, the same bank's next activate waits max(BURST_LEN, remaining RAS) + RP cycles, and also RC from its activate.
- R8: A refresh is held while any bank is open or has not yet met its RC/RP limit; after a refresh, no command of any kind is accepted for RFC cycles.
- R9: A mode-register load is held while any bank is open or not yet able to activate; an activate waits MRD_CYC cycles after a mode-register load.
- R10: Column commands are never delayed by other column commands: reads and writes to an open bank may be accepted on consecutive cycles.
- R11: `refresh_due` is low out of reset and rises after exactly REFI cycles (REFI = floor(T_REFI_NS*1000/CLK_PS)); it stays high until refreshes have cleared the debt.
- R12: Owed refreshes count up to PEND_MAX and no further; each accepted refresh retires one, and `refresh_due` falls when the count reaches zero.
- R13: Command codes on `req_cmd`: 0 activate, 1 read, 2 write, 3 read+auto-precharge, 4 write+auto-precharge, 5 precharge one bank, 6 precharge all, 7 refresh, 8 mode-register load; other codes pass with no timing effect. `issue` = `req_valid` AND `req_ready`, and out of reset an activate is ready at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command offered by the source |
| req_cmd | input | 4 | Command code (see R13) |
| req_bank | input | BW = clog2(NUM_BANKS) | Bank addressed by the command |
| req_ready | output | 1 | All timing rules for the offered command are met |
| issue | output | 1 | Command accepted on this edge |
| refresh_due | output | 1 | At least one refresh is owed |

## Verification
The bench runs the same command sequences on every bank and every ordered pair of banks. Its expected acceptance cycles come from the nanosecond limits at a 10 ns period, and the limits are chosen so that RC, RAS+RP, RRD and the write-recovery sum all give different counts. This shows whether a delay comes from the right rule. For example, the bench checks whether an activate after a precharge is held by RC or by RP, and whether an auto-precharge write is held by its recovery window or by RC. Refresh and mode-load sequences issued while a row is still open show whether the all-idle check is applied. An idle stretch long enough to saturate the debt counter, followed by refreshes timed between interval ticks, shows both the ceiling and the retire-one-per-refresh rule.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [3:0] {
    CMD_ACT  = 4'd0,
    CMD_RD   = 4'd1,
    CMD_WR   = 4'd2,
    CMD_RDA  = 4'd3,
    CMD_WRA  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_PREA = 4'd6,
    CMD_REF  = 4'd7,
    CMD_MRS  = 4'd8
  } cmd_e;

  // nanoseconds to whole clocks, fraction rounded up
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int RCD = 2,
  parameter int RP  = 2,
  parameter int RAS = 4,
  parameter int RC  = 6,
  parameter int BL  = 4,
  parameter int WR  = 2,
  parameter int CW  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  input  logic wr_go,
  input  logic rda_go,
  input  logic wra_go,
  input  logic pre_go,
  output logic act_ok,
  output logic col_ok,
  output logic pre_ok,
  output logic is_open
);
  localparam logic [CW-1:0] L_RCD   = CW'(RCD - 1);
  localparam logic [CW-1:0] L_RAS   = CW'(RAS - 1);
  localparam logic [CW-1:0] L_RC    = CW'(RC - 1);
  localparam logic [CW-1:0] L_RP    = CW'(RP - 1);
  localparam logic [CW-1:0] L_WRPRE = CW'(BL + WR - 2);
  localparam logic [CW-1:0] L_RDAB  = CW'(BL);
  localparam logic [CW-1:0] L_WRAB  = CW'(BL + WR - 1);

  logic [CW-1:0] act_cnt, col_cnt, pre_cnt;
  logic          open_q;

  function automatic logic [CW-1:0] dec(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - CW'(1);
  endfunction

  function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cnt <= '0;
      col_cnt <= '0;
      pre_cnt <= '0;
      open_q  <= 1'b0;
    end else begin
      act_cnt <= dec(act_cnt);
      col_cnt <= dec(col_cnt);
      pre_cnt <= dec(pre_cnt);
      if (act_go) begin
        act_cnt <= mx(dec(act_cnt), L_RC);
        col_cnt <= L_RCD;
        pre_cnt <= L_RAS;
        open_q  <= 1'b1;
      end
      if (wr_go)
        pre_cnt <= mx(dec(pre_cnt), L_WRPRE);
      if (rda_go) begin
        act_cnt <= mx(dec(act_cnt), mx(L_RDAB, pre_cnt) + L_RP);
        open_q  <= 1'b0;
      end
      if (wra_go) begin
        act_cnt <= mx(dec(act_cnt), mx(L_WRAB, pre_cnt) + L_RP);
        open_q  <= 1'b0;
      end
      if (pre_go) begin
        act_cnt <= mx(dec(act_cnt), L_RP);
        open_q  <= 1'b0;
      end
    end
  end

  assign act_ok  = (act_cnt == '0) && !open_q;
  assign col_ok  = (col_cnt == '0);
  assign pre_ok  = (pre_cnt == '0);
  assign is_open = open_q;

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REFI = 1116,
  parameter int PMAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_go,
  output logic due
);
  localparam int RW = $clog2(REFI + 1);
  localparam int PW = $clog2(PMAX + 1);
  localparam logic [RW-1:0] LAST = RW'(REFI - 1);
  localparam logic [PW-1:0] PTOP = PW'(PMAX);

  logic [RW-1:0] tick_cnt;
  logic [PW-1:0] owed;
  logic          tick;

  assign tick = (tick_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      owed     <= '0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + RW'(1);
      case ({tick, ref_go})
        2'b10:   if (owed != PTOP) owed <= owed + PW'(1);
        2'b01:   if (owed != '0)   owed <= owed - PW'(1);
        default: ;
      endcase
    end
  end

  assign due = (owed != '0);

endmodule

// File: rtl/sdram_timing_guard.sv
module sdram_timing_guard
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CLK_PS    = 7000,
  parameter int BURST_LEN = 4,
  parameter int T_RCD_NS  = 15,
  parameter int T_RP_NS   = 15,
  parameter int T_RAS_NS  = 37,
  parameter int T_RC_NS   = 60,
  parameter int T_RFC_NS  = 63,
  parameter int T_RRD_NS  = 14,
  parameter int T_WR_NS   = 14,
  parameter int MRD_CYC   = 2,
  parameter int T_REFI_NS = 7812,
  parameter int PEND_MAX  = 8,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_cmd,
  input  logic [BW-1:0] req_bank,
  output logic          req_ready,
  output logic          issue,
  output logic          refresh_due
);
  localparam int RCD_CYC  = ns_to_cyc(T_RCD_NS, CLK_PS);
  localparam int RP_CYC   = ns_to_cyc(T_RP_NS, CLK_PS);
  localparam int RAS_CYC  = ns_to_cyc(T_RAS_NS, CLK_PS);
  localparam int RC_CYC   = ns_to_cyc(T_RC_NS, CLK_PS);
  localparam int RFC_CYC  = ns_to_cyc(T_RFC_NS, CLK_PS);
  localparam int RRD_CYC  = ns_to_cyc(T_RRD_NS, CLK_PS);
  localparam int WR_CYC   = (CLK_PS >= T_WR_NS * 1000) ? 1 : 2;
  localparam int REFI_CYC = (T_REFI_NS * 1000) / CLK_PS;
  localparam int MAXC     = RC_CYC + RAS_CYC + RP_CYC + BURST_LEN + WR_CYC
                          + RFC_CYC + RRD_CYC + MRD_CYC;
  localparam int CW       = $clog2(MAXC + 1);

  cmd_e cmd;
  assign cmd = cmd_e'(req_cmd);

  logic [NUM_BANKS-1:0] act_ok, col_ok, pre_ok, bank_open;
  logic [CW-1:0]        rrd_cnt, rfc_cnt, mrd_cnt;
  logic                 cmd_ok;

  // ready depends on the offered command, never on req_valid
  always_comb begin
    case (cmd)
      CMD_ACT:                          cmd_ok = act_ok[req_bank] && (rrd_cnt == '0) && (mrd_cnt == '0);
      CMD_RD, CMD_WR, CMD_RDA, CMD_WRA: cmd_ok = col_ok[req_bank];
      CMD_PRE:                          cmd_ok = pre_ok[req_bank];
      CMD_PREA:                         cmd_ok = &pre_ok;
      CMD_REF, CMD_MRS:                 cmd_ok = (&act_ok) && (bank_open == '0);
      default:                          cmd_ok = 1'b1;
    endcase
  end

  assign req_ready = cmd_ok && (rfc_cnt == '0);
  assign issue     = req_valid && req_ready;

  // device-wide windows
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_cnt <= '0;
      rfc_cnt <= '0;
      mrd_cnt <= '0;
    end else begin
      rrd_cnt <= (rrd_cnt == '0) ? '0 : rrd_cnt - CW'(1);
      rfc_cnt <= (rfc_cnt == '0) ? '0 : rfc_cnt - CW'(1);
      mrd_cnt <= (mrd_cnt == '0) ? '0 : mrd_cnt - CW'(1);
      if (issue && cmd == CMD_ACT) rrd_cnt <= CW'(RRD_CYC - 1);
      if (issue && cmd == CMD_REF) rfc_cnt <= CW'(RFC_CYC - 1);
      if (issue && cmd == CMD_MRS) mrd_cnt <= CW'(MRD_CYC - 1);
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit;
    assign hit = issue && (req_bank == BW'(i));
    sdram_bank_timer #(
      .RCD(RCD_CYC), .RP(RP_CYC), .RAS(RAS_CYC), .RC(RC_CYC),
      .BL(BURST_LEN), .WR(WR_CYC), .CW(CW)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_go (hit && cmd == CMD_ACT),
      .wr_go  (hit && cmd == CMD_WR),
      .rda_go (hit && cmd == CMD_RDA),
      .wra_go (hit && cmd == CMD_WRA),
      .pre_go ((hit && cmd == CMD_PRE) || (issue && cmd == CMD_PREA)),
      .act_ok (act_ok[i]),
      .col_ok (col_ok[i]),
      .pre_ok (pre_ok[i]),
      .is_open(bank_open[i])
    );
  end

  sdram_refresh_timer #(.REFI(REFI_CYC), .PMAX(PEND_MAX)) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .ref_go(issue && cmd == CMD_REF),
    .due   (refresh_due)
  );

endmodule

// File: rtl/sdram_guard_checker.sv
module sdram_guard_checker
  import sdram_guard_pkg::*;
#(
  parameter int NB  = 4,
  parameter int BW  = 2,
  parameter int RCD = 2,
  parameter int RRD = 2,
  parameter int RFC = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue,
  input logic [3:0]    req_cmd,
  input logic [BW-1:0] req_bank,
  input logic          refresh_due,
  input logic [NB-1:0] bank_open
);
  localparam int SAT = 1 << 20;

  int since_ref, since_act_any;
  int since_act [NB];
  logic is_col;

  assign is_col = (req_cmd == CMD_RD) || (req_cmd == CMD_WR) ||
                  (req_cmd == CMD_RDA) || (req_cmd == CMD_WRA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_ref     <= SAT;
      since_act_any <= SAT;
      for (int i = 0; i < NB; i++) since_act[i] <= SAT;
    end else begin
      since_ref     <= (issue && req_cmd == CMD_REF) ? 1 : ((since_ref < SAT) ? since_ref + 1 : SAT);
      since_act_any <= (issue && req_cmd == CMD_ACT) ? 1 : ((since_act_any < SAT) ? since_act_any + 1 : SAT);
      for (int i = 0; i < NB; i++)
        since_act[i] <= (issue && req_cmd == CMD_ACT && req_bank == BW'(i)) ? 1 :
                        ((since_act[i] < SAT) ? since_act[i] + 1 : SAT);
    end
  end

  AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && is_col) |-> (since_act[req_bank] >= RCD)) else $error("col before RCD"); // R1

  AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && req_cmd == CMD_ACT) |-> (since_act_any >= RRD)) else $error("act spacing"); // R4

  AST_QUIET_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (since_ref >= RFC)) else $error("command inside refresh window"); // R8

  AST_REF_BANKS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && req_cmd == CMD_REF) |-> (bank_open == '0)) else $error("refresh with open bank"); // R8

  AST_DUE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_due && !(issue && req_cmd == CMD_REF)) |=> refresh_due) else $error("due dropped"); // R11

endmodule

bind sdram_timing_guard sdram_guard_checker #(
  .NB(NUM_BANKS), .BW(BW), .RCD(RCD_CYC), .RRD(RRD_CYC), .RFC(RFC_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue      (issue),
  .req_cmd    (req_cmd),
  .req_bank   (req_bank),
  .refresh_due(refresh_due),
  .bank_open  (bank_open)
);

// File: tb/sim_sdram_timing_guard.sv
`timescale 1ns/1ps
module sim_sdram_timing_guard;
  localparam int CK   = 10000;
  localparam int B_BL = 4;
  localparam int B_RCD = (15 * 1000 + CK - 1) / CK;   // 2
  localparam int B_RP  = (15 * 1000 + CK - 1) / CK;   // 2
  localparam int B_RAS = (37 * 1000 + CK - 1) / CK;   // 4
  localparam int B_RC  = (90 * 1000 + CK - 1) / CK;   // 9
  localparam int B_RFC = (63 * 1000 + CK - 1) / CK;   // 7
  localparam int B_RRD = (25 * 1000 + CK - 1) / CK;   // 3
  localparam int B_WR  = (CK >= 14000) ? 1 : 2;       // 2
  localparam int B_MRD = 3;
  localparam int B_REFI = (200 * 1000) / CK;          // 20
  localparam int B_PMAX = 3;

  localparam logic [3:0] ACT = 4'd0, RD = 4'd1, WR = 4'd2, RDA = 4'd3, WRA = 4'd4,
                         PRE = 4'd5, PREA = 4'd6, REF = 4'd7, MRS = 4'd8;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [3:0] req_cmd = '0;
  logic [1:0] req_bank = '0;
  logic req_ready, issue, refresh_due;
  int cyc = 0, c0 = 0, n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_timing_guard #(
    .NUM_BANKS(4), .CLK_PS(CK), .BURST_LEN(B_BL), .T_RCD_NS(15), .T_RP_NS(15),
    .T_RAS_NS(37), .T_RC_NS(90), .T_RFC_NS(63), .T_RRD_NS(25), .T_WR_NS(14),
    .MRD_CYC(B_MRD), .T_REFI_NS(200), .PEND_MAX(B_PMAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_ready(req_ready), .issue(issue), .refresh_due(refresh_due)
  );

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // offer a command from a negedge; t = cycle stamp of acceptance; returns at next negedge
  task automatic send(input logic [3:0] c, input int b, output int t);
    int w = 0;
    req_valid = 1'b1; req_cmd = c; req_bank = 2'(b);
    #1;
    while (!req_ready && w < 64) begin
      @(negedge clk); #1; w++;
    end
    if (w >= 64) begin
      n_chk++; n_bad++;
      $display("FAIL R13: command %0d bank %0d never accepted (got 0 expected 1)", c, b);
    end
    t = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic peek(input logic [3:0] c, input int b, output logic r);
    req_cmd = c; req_bank = 2'(b);
    #1;
    r = req_ready;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ta, tb, tr, tw, tp, ta2, tq, tf, tf2, tm;
    logic r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    c0 = cyc;

    // reset state
    peek(ACT, 0, r);
    chk("R13 act ready after reset", int'(r), 1);
    chk("R13 no issue without valid", int'(issue), 0);
    chk("R11 due low after reset", int'(refresh_due), 0);

    // refresh interval
    while (cyc != c0 + B_REFI - 1) @(negedge clk);
    chk("R11 due before interval", int'(refresh_due), 0);
    @(negedge clk);
    chk("R11 due at interval", int'(refresh_due), 1);

    for (int b = 0; b < 4; b++) begin
      // basic row cycle with write recovery
      send(ACT, b, ta);
      send(RD, b, tr);  chk("R1 act->read", tr - ta, B_RCD);
      send(WR, b, tw);  chk("R10 read->write back to back", tw - tr, 1);
      send(PRE, b, tp); chk("R5 write->precharge", tp - tw, imax(B_BL - 1 + B_WR, ta + B_RAS - tw));
      send(ACT, b, ta2); chk("R3 precharge->act", ta2 - ta, imax(B_RC, tp - ta + B_RP));
      send(PRE, b, tp); chk("R2 act->precharge", tp - ta2, B_RAS);
      idle(15);
      // row cycle dominates
      send(ACT, b, ta);
      send(PRE, b, tp); chk("R2 act->precharge", tp - ta, B_RAS);
      send(ACT, b, ta2); chk("R3 row cycle", ta2 - ta, imax(B_RC, B_RAS + B_RP));
      send(PRE, b, tp);
      idle(15);
      // write with auto precharge
      send(ACT, b, ta); idle(4);
      send(WRA, b, tw);
      send(ACT, b, ta2);
      chk("R6 wra->act", ta2 - ta,
          imax(B_RC, tw - ta + imax(B_BL - 1 + B_WR, imax(0, ta + B_RAS - tw)) + B_RP));
      send(PRE, b, tp);
      idle(15);
      // read with auto precharge
      send(ACT, b, ta); idle(6);
      send(RDA, b, tr);
      send(ACT, b, ta2);
      chk("R7 rda->act", ta2 - ta,
          imax(B_RC, tr - ta + imax(B_BL, imax(0, ta + B_RAS - tr)) + B_RP));
      send(PRE, b, tp);
      idle(15);
    end

    // activate spacing over all ordered bank pairs
    for (int b1 = 0; b1 < 4; b1++) begin
      for (int b2 = 0; b2 < 4; b2++) begin
        if (b1 != b2) begin
          send(ACT, b1, ta);
          send(ACT, b2, tb); chk("R4 act->act other bank", tb - ta, B_RRD);
          send(RD, b1, tr);  chk("R1 expired bank not held", tr - tb, 1);
          send(WR, b1, tw);  chk("R10 column every clock", tw - tr, 1);
          send(PREA, 0, tq); chk("R2 precharge all", tq - tb, imax(B_RAS, tw + B_BL - 1 + B_WR - tb));
          idle(15);
        end
      end
    end

    // refresh and mode load
    send(ACT, 0, ta);
    peek(REF, 0, r); chk("R8 refresh held while open", int'(r), 0);
    peek(MRS, 0, r); chk("R9 mode load held while open", int'(r), 0);
    send(PRE, 0, tp);
    send(REF, 0, tf);  chk("R8 precharge->refresh", tf - ta, imax(B_RC, tp - ta + B_RP));
    send(REF, 0, tf2); chk("R8 refresh->refresh", tf2 - tf, B_RFC);
    send(ACT, 1, ta);  chk("R8 refresh->act", ta - tf2, B_RFC);
    send(PRE, 1, tp);
    idle(15);
    send(MRS, 0, tm);
    send(ACT, 2, ta);  chk("R9 mode load->act", ta - tm, B_MRD);
    send(PRE, 2, tp);
    idle(15);

    // debt ceiling
    idle(B_REFI * 5);
    chk("R11 due held without refresh", int'(refresh_due), 1);
    while (((cyc - c0) % B_REFI) != 1) @(negedge clk);
    for (int k = 0; k < B_PMAX - 1; k++) send(REF, 0, tf);
    chk("R12 debt remains", int'(refresh_due), 1);
    send(REF, 0, tf);
    chk("R12 debt cleared at ceiling", int'(refresh_due), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule